// File: doc/BRIEF.md
# SMBus Alert Responder

This block raises the shared, active-low SMBus alert line when an enabled status condition is pending, and answers the host's alert-response query. Status arrives as three category bits: temperature, voltage and fan. Each bit is gated by its own category enable. A single interrupt-enable bit gates the whole alert. The alert is latched only on a monitoring-cycle strobe. Software sets the interrupt-enable bit through a one-cycle set input.

When the host reads from the alert response address, the block acknowledges the address byte only if it is the one asserting the alert. It then returns its own 7-bit device address, MSB first, in the upper seven bits of the data byte. The host ends the read with a NACK and a STOP. The block clears its interrupt-enable bit when its acknowledge is clocked, and this releases the alert line. The alert can return only after software sets the enable again and a later monitoring strobe sees the cause still present.

A configuration input removes the dedicated alert pin. In that mode the line is never pulled, and the block answers the query only when a separate response flag is set and an enabled condition is pending. SCL and SDA are sampled through two-flop synchronizers on a system clock at least eight times the SCL rate. Both open-drain outputs are given as pull-low enables.

Top module: `smb_alert_responder`

## Requirements
- R1: `alert_oe` is high only if, in the previous cycle, `int_en_o` was 1, at least one category had both its status and enable bits set, and `no_pin_mode` was 0. When the pending condition disappears, `alert_oe` drops.
- R2: A `mon_strobe` pulse while `int_en_o`=1, an enabled status is pending and `no_pin_mode`=0 sets `alert_oe` one cycle later.
- R3: With the block responding, an address byte of 0x19 (address 0001100, RD=1) is acknowledged by pulling SDA low during the ninth clock.
- R4: After the acknowledge, the block shifts out the data byte {dev_addr, 0} MSB first and then releases SDA for the host's NACK. SDA output changes only while SCL is low.
- R5: When its acknowledge of the alert response address is clocked, the block clears `int_en_o` and releases `alert_oe`.
- R6: After R5, `alert_oe` stays released across monitoring strobes until `int_en_set` is pulsed. Even then it waits for the next `mon_strobe`.
- R7: An address byte other than 0x19, including the write form 0x18, is not acknowledged and leaves `int_en_o` and `alert_oe` unchanged.
- R8: While the block is not asserting the alert, the query is not acknowledged.
- R9: With `no_pin_mode`=1, `alert_oe` stays 0. The query is answered, and the enable cleared, only when `ara_en`=1, `int_en_o`=1 and an enabled status is pending.
- R10: A STOP or repeated START before the acknowledge aborts the transaction, with SDA released and `int_en_o` kept. A repeated START begins a fresh address phase.
- R11: During and after reset, `sda_oe`, `alert_oe` and `int_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| alert_oe | output | 1 | Pull the alert line low when 1 |
| stat_temp | input | 1 | Temperature status bit |
| stat_volt | input | 1 | Voltage status bit |
| stat_fan | input | 1 | Fan status bit |
| en_temp | input | 1 | Temperature category enable |
| en_volt | input | 1 | Voltage category enable |
| en_fan | input | 1 | Fan category enable |
| int_en_set | input | 1 | One-cycle pulse that sets the interrupt enable |
| int_en_o | output | 1 | Current interrupt-enable bit |
| dev_addr | input | 7 | Device address returned to the host |
| mon_strobe | input | 1 | Monitoring-cycle strobe |
| no_pin_mode | input | 1 | Configuration without the alert pin |
| ara_en | input | 1 | Response flag used in pin-less mode |

## Verification
A wrong gating or latch state shows on `alert_oe` within two system clocks of a strobe or a status change. A wrong shift-register or bit-counter state shows at the ports in two ways: as a missing or misplaced acknowledge on the ninth SCL pulse, or as a corrupted data byte in the same read. A wrong enable-clear decision shows in `int_en_o` and `alert_oe` as soon as the transaction ends. It also shows in whether the next monitoring strobe re-raises the alert.

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       alert_oe,
  input  logic       stat_temp,
  input  logic       stat_volt,
  input  logic       stat_fan,
  input  logic       en_temp,
  input  logic       en_volt,
  input  logic       en_fan,
  input  logic       int_en_set,
  output logic       int_en_o,
  input  logic [6:0] dev_addr,
  input  logic       mon_strobe,
  input  logic       no_pin_mode,
  input  logic       ara_en
);
  localparam logic [7:0] ARA_RD = {ARA_ADDR, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADEC, S_ACK, S_DATA, S_HACK} st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;
  logic [2:0] cnt;
  logic [7:0] sh, tx;
  logic       int_en_q, alert_q, sda_q;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire pending  = (stat_temp & en_temp) | (stat_volt & en_volt) | (stat_fan & en_fan);
  wire respond  = no_pin_mode ? (ara_en & int_en_q & pending) : alert_q;
  wire ack_clr  = (st == S_ACK) & scl_rise;

  assign sda_oe   = sda_q;
  assign alert_oe = alert_q;
  assign int_en_o = int_en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11;
      scl_p  <= 1'b1;  sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          int_en_q <= 1'b0;
    else if (ack_clr)    int_en_q <= 1'b0;
    else if (int_en_set) int_en_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) alert_q <= 1'b0;
    else        alert_q <= (mon_strobe | alert_q) & int_en_q & pending & ~no_pin_mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; sda_q <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; cnt <= '0; sda_q <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; sda_q <= 1'b0;
    end else begin
      case (st)
        S_ADDR: if (scl_rise) begin
          sh <= {sh[6:0], sda_s};
          if (cnt == 3'd7) st <= S_ADEC;
          else             cnt <= cnt + 3'd1;
        end
        S_ADEC: if (scl_fall) begin
          if (sh == ARA_RD && respond) begin
            st <= S_ACK; sda_q <= 1'b1;
          end else st <= S_IDLE;
        end
        S_ACK: if (scl_fall) begin
          st <= S_DATA; cnt <= '0;
          tx <= {dev_addr, 1'b0};
          sda_q <= ~dev_addr[6];
        end
        S_DATA: if (scl_fall) begin
          if (cnt == 3'd7) begin
            st <= S_HACK; sda_q <= 1'b0;
          end else begin
            cnt <= cnt + 3'd1;
            tx <= {tx[6:0], 1'b0};
            sda_q <= ~tx[6];
          end
        end
        S_HACK: if (scl_rise) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/smb_alert_responder_chk.sv
module smb_alert_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       alert_oe,
  input logic       stat_temp,
  input logic       stat_volt,
  input logic       stat_fan,
  input logic       en_temp,
  input logic       en_volt,
  input logic       en_fan,
  input logic       int_en_o,
  input logic       mon_strobe,
  input logic       no_pin_mode
);
  wire cause = (stat_temp & en_temp) | (stat_volt & en_volt) | (stat_fan & en_fan);

  a_r1_alert_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    alert_oe |-> $past(int_en_o && cause && !no_pin_mode));

  a_r6_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_oe) |-> $past(mon_strobe));

  a_r5_clear_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_en_o) |-> $past(sda_oe));

  a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  a_r9_no_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (no_pin_mode && $past(no_pin_mode)) |-> !alert_oe);

  always_comb
    if (!rst_n) a_r11_reset_released: assert (!sda_oe && !alert_oe && !int_en_o);
endmodule

bind smb_alert_responder smb_alert_responder_chk chk_i (.*);

// File: tb/smb_alert_responder_tb_top.sv
module smb_alert_responder_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, host_low = 1'b0;
  logic st_t = 0, st_v = 0, st_f = 0, e_t = 0, e_v = 0, e_f = 0;
  logic ie_set = 0, mon = 0, nopin = 0, araen = 0;
  logic [6:0] addr = 7'h2a;
  logic sda_oe, alert_oe, int_en;
  logic sda_line;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;
  assign sda_line = ~(host_low | sda_oe);

  smb_alert_responder dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .alert_oe(alert_oe), .stat_temp(st_t), .stat_volt(st_v), .stat_fan(st_f),
    .en_temp(e_t), .en_volt(e_v), .en_fan(e_f), .int_en_set(ie_set),
    .int_en_o(int_en), .dev_addr(addr), .mon_strobe(mon),
    .no_pin_mode(nopin), .ara_en(araen));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_mon(); mon = 1; cyc(1); mon = 0; cyc(2); endtask
  task automatic pulse_set(); ie_set = 1; cyc(1); ie_set = 0; cyc(2); endtask

  task automatic bus_start();
    host_low = 0; cyc(Q); scl = 1; cyc(Q); host_low = 1; cyc(Q); scl = 0; cyc(Q);
  endtask
  task automatic bus_stop();
    host_low = 1; cyc(Q); scl = 1; cyc(Q); host_low = 0; cyc(Q);
  endtask
  task automatic send_bit(input logic b);
    host_low = ~b; cyc(Q); scl = 1; cyc(Q); scl = 0; cyc(Q);
  endtask
  task automatic recv_bit(output logic b);
    host_low = 0; cyc(Q); scl = 1; cyc(Q/2); b = sda_line; cyc(Q/2); scl = 0; cyc(Q);
  endtask

  task automatic ara(input logic [7:0] ab, output logic ackb, output logic [7:0] d);
    logic b;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(ab[i]);
    recv_bit(ackb);
    d = 8'h00;
    if (!ackb) begin
      for (int i = 0; i < 8; i++) begin recv_bit(b); d = {d[6:0], b}; end
      send_bit(1'b1);
    end
    bus_stop();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic ackb, prev;
    logic [7:0] d;
    cyc(3);
    chk("R11 reset", {sda_oe, alert_oe, int_en}, 0);
    rst_n = 1; cyc(3);
    chk("R11 after reset", {sda_oe, alert_oe, int_en}, 0);

    // R8: enable off, nothing pending -> no ack
    ara(8'h19, ackb, d);
    chk("R8 no alert nack", ackb, 1);

    // R1/R2 gating sweep over all status/enable combinations
    pulse_set();
    prev = 0;
    for (int c = 0; c < 64; c++) begin
      {e_f, e_v, e_t, st_f, st_v, st_t} = c[5:0];
      cyc(3);
      chk("R1 no rise without strobe", alert_oe, prev & |({st_f, st_v, st_t} & {e_f, e_v, e_t}));
      pulse_mon();
      prev = |({st_f, st_v, st_t} & {e_f, e_v, e_t});
      chk("R2 strobe latch", alert_oe, prev);
    end

    // Address sweep: ARA, clear, re-enable sequence
    {e_f, e_v, e_t, st_f, st_v, st_t} = 6'b001001;
    for (int a = 0; a < 136; a += 9) begin
      addr = (a > 127) ? 7'h7f : a[6:0];
      pulse_set(); pulse_mon();
      chk("R2 alert set", alert_oe, 1);
      ara(8'h19, ackb, d);
      chk("R3 ack", ackb, 0);
      chk("R4 byte", d, {addr, 1'b0});
      chk("R5 enable cleared", int_en, 0);
      chk("R5 alert released", alert_oe, 0);
      pulse_mon();
      chk("R6 strobe without enable", alert_oe, 0);
      pulse_set(); cyc(4);
      chk("R6 enable without strobe", alert_oe, 0);
      pulse_mon();
      chk("R6 reasserted", alert_oe, 1);
    end

    // R7: wrong address and write form
    ara(8'h33, ackb, d);
    chk("R7 wrong addr nack", ackb, 1);
    chk("R7 enable kept", {int_en, alert_oe}, 2'b11);
    ara(8'h18, ackb, d);
    chk("R7 write form nack", ackb, 1);
    chk("R7 alert kept", alert_oe, 1);

    // R10: STOP before ack, then repeated START
    bus_start(); send_bit(0); send_bit(0); send_bit(0); send_bit(1);
    bus_stop(); cyc(4);
    chk("R10 stop abort sda", {sda_line, sda_oe}, 2'b10);
    chk("R10 enable kept", int_en, 1);
    bus_start(); send_bit(0); send_bit(0); send_bit(1);
    host_low = 0; cyc(Q); scl = 1; cyc(Q); host_low = 1; cyc(Q); scl = 0; cyc(Q);
    for (int i = 7; i >= 0; i--) send_bit(8'h19 >> i);
    recv_bit(ackb);
    chk("R10 restart ack", ackb, 0);
    d = 0;
    for (int i = 0; i < 8; i++) begin recv_bit(prev); d = {d[6:0], prev}; end
    send_bit(1); bus_stop();
    chk("R10 restart byte", d, {addr, 1'b0});
    chk("R10 restart cleared", int_en, 0);

    // R9: pin-less configuration
    nopin = 1; pulse_set(); pulse_mon();
    chk("R9 no pin alert", alert_oe, 0);
    ara(8'h19, ackb, d);
    chk("R9 flag off nack", ackb, 1);
    araen = 1; addr = 7'h55;
    ara(8'h19, ackb, d);
    chk("R9 flag on ack", ackb, 0);
    chk("R9 byte", d, 8'haa);
    chk("R9 enable cleared", int_en, 0);
    ara(8'h19, ackb, d);
    chk("R9 enable off nack", ackb, 1);

    finish_run();
  end
endmodule